// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

The block holds two free-running 32-bit counters. Each one has a compare register of its own. When an enabled counter's value equals its compare value, the channel latches a pending flag and raises its interrupt line. Software sees all state through a small word-addressed register bus. One shared control word carries the two enable bits in its low half and the two pending flags in its upper half. Each channel has a compare word and a count word.

A typical use is a one-shot event timer. Software reads the current count and adds a delta modulo 2^32. It writes the sum into the compare register, then waits for the interrupt. To acknowledge the event, software writes the compare register again, usually with the current count. A match is an equality test, so a target that lies past the wrap of the counter is reached in the normal way.

Top module: `dual_match_timer`

## Requirements
- R1: After reset both counts read 0, both compares read 0xFFFFFFFF, the control word reads 0 and both interrupt lines are low.
- R2: Word address 0 is the control word. Address 1 is compare 0, address 2 is count 0, address 3 is compare 1 and address 4 is count 1. Every compare and count word reads back the last value written to it. Addresses 5 to 7 read 0 and ignore writes.
- R3: A counter advances by one on each clock while its enable bit (control bit n) is set, and it holds its value while the bit is clear.
- R4: A counter wraps from 0xFFFFFFFF to 0.
- R5: If an enabled channel's count equals its compare value, its pending flag (control bit 16+n) reads 1 after the next clock edge. The flag stays set until it is acknowledged. A channel that is disabled never sets its flag.
- R6: Any write to a channel's compare word clears that channel's pending flag. If the write falls in the cycle in which the flag would set, the clear wins.
- R7: A channel's interrupt line is high exactly when its pending flag and its enable bit are both set. Disabling the channel masks the line but keeps the flag.
- R8: Writes to control bits 16 and 17 have no effect. Control bits other than 0, 1, 16 and 17 always read 0.
- R9: The two channels are independent. Activity on one channel never changes the other channel's count, compare value or pending flag.
- R10: A write to a count word loads the written value even while the channel is enabled. Counting resumes from the loaded value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| irqOut | output | 2 | Per-channel interrupt lines |

## Verification
A corrupted counter shows up in the count word one clock after the corruption. It also moves the clock edge at which the pending flag rises, so the flag reads 1 one cycle too early or too late, or never. A wrong pending or enable state shows on the interrupt line and on control bits 16 to 17 within one cycle. The sweep presets each channel on both sides of the wrap point. It checks the flag on the exact edge where it should rise, and it checks that the idle channel has not moved.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int DMT_CH       = 2;
  localparam int DMT_DATA_W   = 32;
  localparam int DMT_ADDR_W   = 3;
  localparam int DMT_PEND_LSB = 16;

  typedef struct packed {
    logic              ctlWr;
    logic [DMT_CH-1:0] cmpWr;
    logic [DMT_CH-1:0] cntWr;
  } dmt_strobe_t;
endpackage

// File: rtl/dmt_chan.sv
module dmt_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             cmpWr,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic             pendQ,
  output logic             irq
);
  logic hit;

  assign hit = en && (cntQ == cmpQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      cmpQ  <= '1;
      pendQ <= 1'b0;
    end else begin
      if (cntWr)   cntQ <= wdata;
      else if (en) cntQ <= cntQ + 1'b1;
      if (cmpWr) cmpQ <= wdata;
      if (cmpWr)    pendQ <= 1'b0;
      else if (hit) pendQ <= 1'b1;
    end
  end

  assign irq = pendQ & en;
endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int NUM_CH = DMT_CH,
  parameter int CNT_W  = DMT_DATA_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dmt_strobe_t                  stb,
  input  logic [CNT_W-1:0]             wdata,
  output logic [NUM_CH-1:0]            enQ,
  output logic [NUM_CH-1:0]            pendQ,
  output logic [NUM_CH-1:0][CNT_W-1:0] cntQ,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmpQ,
  output logic [NUM_CH-1:0]            irq
);
  always_ff @(posedge clk) begin
    if (!rstN)          enQ <= '0;
    else if (stb.ctlWr) enQ <= wdata[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    dmt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk   (clk),
      .rstN  (rstN),
      .en    (enQ[n]),
      .cmpWr (stb.cmpWr[n]),
      .cntWr (stb.cntWr[n]),
      .wdata (wdata),
      .cntQ  (cntQ[n]),
      .cmpQ  (cmpQ[n]),
      .pendQ (pendQ[n]),
      .irq   (irq[n])
    );
  end
endmodule

// File: rtl/dmt_regctl.sv
module dmt_regctl
  import dmt_pkg::*;
#(
  parameter int NUM_CH = DMT_CH,
  parameter int DATA_W = DMT_DATA_W,
  parameter int ADDR_W = DMT_ADDR_W
) (
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [NUM_CH-1:0]             enQ,
  input  logic [NUM_CH-1:0]             pendQ,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cntQ,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cmpQ,
  output dmt_strobe_t                   stb,
  output logic [DATA_W-1:0]             busRdata
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = '0;

  logic wrAcc;
  assign wrAcc = busSel && busWr;

  always_comb begin
    stb.ctlWr = wrAcc && (busAddr == CTL_ADDR);
    for (int n = 0; n < NUM_CH; n++) begin
      stb.cmpWr[n] = wrAcc && (busAddr == ADDR_W'(1 + 2*n));
      stb.cntWr[n] = wrAcc && (busAddr == ADDR_W'(2 + 2*n));
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTL_ADDR) begin
      busRdata[NUM_CH-1:0]                          = enQ;
      busRdata[DMT_PEND_LSB +: NUM_CH]              = pendQ;
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == ADDR_W'(1 + 2*n)) busRdata = cmpQ[n];
      if (busAddr == ADDR_W'(2 + 2*n)) busRdata = cntQ[n];
    end
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int DATA_W = DMT_DATA_W,
  parameter int ADDR_W = DMT_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DMT_CH-1:0] irqOut
);
  dmt_strobe_t                     stb;
  logic [DMT_CH-1:0]               enQ;
  logic [DMT_CH-1:0]               pendQ;
  logic [DMT_CH-1:0][DATA_W-1:0]   cntQ;
  logic [DMT_CH-1:0][DATA_W-1:0]   cmpQ;

  dmt_regctl #(.NUM_CH(DMT_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .enQ      (enQ),
    .pendQ    (pendQ),
    .cntQ     (cntQ),
    .cmpQ     (cmpQ),
    .stb      (stb),
    .busRdata (busRdata)
  );

  dmt_datapath #(.NUM_CH(DMT_CH), .CNT_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (busWdata),
    .enQ   (enQ),
    .pendQ (pendQ),
    .cntQ  (cntQ),
    .cmpQ  (cmpQ),
    .irq   (irqOut)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int DATA_W = DMT_DATA_W,
  parameter int ADDR_W = DMT_ADDR_W
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busSel,
  input logic                          busWr,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busRdata,
  input logic [DMT_CH-1:0]             irqOut,
  input dmt_strobe_t                   stb,
  input logic [DMT_CH-1:0]             enQ,
  input logic [DMT_CH-1:0]             pendQ,
  input logic [DMT_CH-1:0][DATA_W-1:0] cntQ,
  input logic [DMT_CH-1:0][DATA_W-1:0] cmpQ
);
  for (genvar n = 0; n < DMT_CH; n++) begin : g_chk
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
      (!enQ[n] && !stb.cntWr[n]) |=> $stable(cntQ[n]));
    a_r3_step_when_on: assert property (@(posedge clk) disable iff (!rstN)
      (enQ[n] && !stb.cntWr[n]) |=> (cntQ[n] == $past(cntQ[n]) + 1'b1));
    a_r5_set_on_match: assert property (@(posedge clk) disable iff (!rstN)
      (enQ[n] && (cntQ[n] == cmpQ[n]) && !stb.cmpWr[n]) |=> pendQ[n]);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[n] && !stb.cmpWr[n]) |=> pendQ[n]);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      stb.cmpWr[n] |=> !pendQ[n]);
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[n] |-> (pendQ[n] && enQ[n]));
  end

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == '0) |->
      (busRdata[DATA_W-1:DMT_PEND_LSB+DMT_CH] == '0 &&
       busRdata[DMT_PEND_LSB-1:DMT_CH] == '0));
endmodule

bind dual_match_timer dmt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .stb      (stb),
  .enQ      (enQ),
  .pendQ    (pendQ),
  .cntQ     (cntQ),
  .cmpQ     (cmpQ)
);

// File: tb/dual_match_timer_test.sv
`timescale 1ns/1ps
module dual_match_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_match_timer uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; performs one write on the next posedge; returns at negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #0.5 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [2:0] cmpA(input int ch); return 3'(1 + 2*ch); endfunction
  function automatic logic [2:0] cntA(input int ch); return 3'(2 + 2*ch); endfunction

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, other;
    logic [31:0] bases [3];
    bases[0] = 32'hFFFF_FFF8; bases[1] = 32'h0000_0000; bases[2] = 32'h7FFF_FFFD;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctl", v, 32'h0);
    for (int ch = 0; ch < 2; ch++) begin
      rd(cntA(ch), v); check("R1 count", v, 32'h0);
      rd(cmpA(ch), v); check("R1 compare", v, 32'hFFFF_FFFF);
    end
    check("R1 irq", {30'd0, irqOut}, 32'h0);

    // R2 map, read-back, unmapped addresses
    wr(3'd1, 32'hA5A5_0001); wr(3'd2, 32'h1234_5678);
    wr(3'd3, 32'h5A5A_0003); wr(3'd4, 32'h8765_4321);
    rd(3'd1, v); check("R2 cmp0", v, 32'hA5A5_0001);
    rd(3'd2, v); check("R2 cnt0", v, 32'h1234_5678);
    rd(3'd3, v); check("R2 cmp1", v, 32'h5A5A_0003);
    rd(3'd4, v); check("R2 cnt1", v, 32'h8765_4321);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), v); check("R2 unmapped", v, 32'h0);
    end
    rd(3'd2, v); check("R2 unmapped write no effect", v, 32'h1234_5678);

    // R8 pending positions ignored, unused bits zero
    wr(3'd1, 32'hFFFF_FFF0); wr(3'd3, 32'hFFFF_FFF0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R8 ctl readback", v, 32'h0000_0003);
    wr(3'd0, 32'h0);

    // R3 hold while disabled
    rd(3'd2, other);
    repeat (5) @(negedge clk);
    rd(3'd2, v); check("R3 hold disabled", v, other);

    // Sweep: channel x base x delta (R3 R4 R5 R6 R7 R9)
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < 3; b++) begin
        for (int d = 0; d < 12; d++) begin
          logic [31:0] c;
          c = bases[b];
          wr(3'd0, 32'h0);
          wr(cntA(ch), c);
          wr(cmpA(ch), c + 32'(d));
          rd(cntA(1-ch), other);
          wr(3'd0, 32'(1 << ch));
          repeat (d) @(negedge clk);
          rd(cntA(ch), v); check("R3 count before match", v, c + 32'(d));
          rd(3'd0, v); check("R5 pending before match", v[16+ch], 1'b0);
          @(negedge clk);
          rd(3'd0, v); check("R5 pending at match", v[16+ch], 1'b1);
          check("R9 other pending", v[17-ch], 1'b0);
          check("R7 irq high", irqOut[ch], 1'b1);
          rd(cntA(ch), v); check("R4 count past match", v, c + 32'(d) + 32'd1);
          repeat (2) @(negedge clk);
          rd(3'd0, v); check("R5 pending sticky", v[16+ch], 1'b1);
          rd(cntA(1-ch), v); check("R9 other count", v, other);
          rd(cntA(ch), v);
          wr(cmpA(ch), v);
          rd(3'd0, v); check("R6 ack clears", v[16+ch], 1'b0);
          check("R7 irq low after ack", irqOut[ch], 1'b0);
        end
      end
    end

    // R7 masking keeps flag
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd10); wr(3'd1, 32'd10);
    wr(3'd0, 32'h1);
    @(negedge clk);
    check("R7 irq set", irqOut[0], 1'b1);
    wr(3'd0, 32'h0);
    check("R7 irq masked", irqOut[0], 1'b0);
    rd(3'd0, v); check("R7 flag kept", v, 32'h0001_0000);
    wr(3'd0, 32'h1);
    check("R7 irq restored", irqOut[0], 1'b1);

    // R6 clear priority over same-cycle set
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd100); wr(3'd1, 32'd103);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    wr(3'd1, 32'd500);
    rd(3'd0, v); check("R6 clear wins", v[16], 1'b0);
    check("R6 irq low", irqOut[0], 1'b0);

    // R4 wrap at all ones
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R10 preset while enabled", v, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(3'd2, v); check("R4 wrap", v, 32'h0);
    @(negedge clk);
    rd(3'd2, v); check("R10 resumes", v, 32'h1);

    // R5 disabled channel never sets
    wr(3'd0, 32'h0);
    wr(3'd4, 32'd7); wr(3'd3, 32'd7);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R5 disabled no set", v[17], 1'b0);
    check("R7 disabled irq", irqOut[1], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule